// File: doc/BRIEF.md
# Iterative Restoring Integer Divider

This block divides one 32-bit integer by another over a fixed number of clock cycles, producing one quotient bit per cycle with a restoring shift-and-subtract loop. A caller presents the dividend, the divisor and a 6-bit operation code, then pulses a start input. The block reports that it is busy while the division runs. When the quotient is ready it raises a one-cycle completion pulse. The quotient stays on its output until the next completion.

Signed division works on operand magnitudes. The sign of the result is taken from the top bit of the exclusive-OR of the two operands, and the quotient is negated after the last iteration when that sign is set. One register starts out holding the dividend. Quotient bits shift into it from the bottom as dividend bits leave at the top. A remainder register, cleared at every start, collects the dividend bits. The block has no remainder output, no overflow trap and no divide-by-zero trap. A zero divisor simply runs through the loop.

Top module: `iter_divider`

## Requirements
- R1: While reset is low at a clock edge, the block clears `busy_o`, `done_o` and `quotient_o` to zero after that edge.
- R2: A start pulse seen while the block is idle is accepted, and `busy_o` is high from the next cycle until the completion pulse. A start pulse seen while `busy_o` is high is ignored, together with the operands presented with it.
- R3: `done_o` is high for exactly one cycle. It appears after the 34th rising edge counted from the edge that accepted the start (32 iterations, one sign-fix cycle, one load cycle).
- R4: Operation code 0x24 gives the unsigned quotient floor(dividend / divisor) for a nonzero divisor.
- R5: Operation code 0x25 gives the signed quotient, truncated toward zero. It is negative exactly when the top bits of dividend and divisor differ (and the magnitude quotient is nonzero).
- R6: Any operation code other than 0x25 is treated as unsigned division.
- R7: A zero divisor gives 0xFFFFFFFF for unsigned division. For signed division it gives 0xFFFFFFFF when the dividend is non-negative and 0x00000001 when the dividend is negative.
- R8: A dividend of 0x80000000 under signed division is taken as the magnitude 2^31. Divided by -1 or 1 it yields 0x80000000, and divided by 2 it yields 0xC0000000.
- R9: `quotient_o` changes only in the cycle in which `done_o` is high, and holds its value in every other cycle.
- R10: A start pulse in the same cycle as `done_o` is accepted and begins a new division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a division when idle |
| op_i | input | 6 | Operation code: 0x25 signed, anything else unsigned |
| dividend_i | input | 32 | Dividend, captured at start |
| divisor_i | input | 32 | Divisor, captured at start |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle pulse when the quotient is valid |
| quotient_o | output | 32 | Quotient of the last completed division |

## Verification
The completion pulse of one division and the acceptance of the next start can fall in the same cycle, because the block is already idle while `done_o` is high. The bench issues each new start at the same falling edge where it sees `done_o`, so almost every division starts back to back with its predecessor. Each result is judged by its latency and by its value against a bench model. Separate runs leave idle gaps, inject starts mid-run that must be ignored, and confirm that the quotient holds between pulses.

// File: rtl/iter_divider_pkg.sv
// Package for the iterative divider: the controller state type and operation codes.
package iter_divider_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    localparam logic [5:0] OPC_SIGNED   = 6'h25;
    localparam logic [5:0] OPC_UNSIGNED = 6'h24;

endpackage

// File: rtl/div_sign_prep.sv
// div_sign_prep: turns the raw operands into the magnitudes used by the loop
// and derives the sign of the final quotient.
// Assumes two's-complement operands; the most negative value maps to the
// unsigned magnitude 2^(W-1), which the unsigned loop handles directly.
module div_sign_prep #(
    parameter int W = 32
) (
    input  logic         is_signed_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] num_mag_o,
    output logic [W-1:0] den_mag_o,
    output logic         negate_o
);

    // Magnitudes and result sign from the operand top bits.
    always_comb begin
        negate_o  = is_signed_i & (num_i[W-1] ^ den_i[W-1]);
        num_mag_o = (is_signed_i && num_i[W-1]) ? (~num_i + 1'b1) : num_i;
        den_mag_o = (is_signed_i && den_i[W-1]) ? (~den_i + 1'b1) : den_i;
    end

endmodule

// File: rtl/div_step.sv
// div_step: one restoring iteration. Shifts the remainder:dividend pair left
// by one, compares the widened remainder with the divisor, subtracts on
// success and shifts the resulting quotient bit into the shared register.
// Assumes W >= 2.
module div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] work_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] work_o
);

    logic [W:0]   widened;
    logic         fits;
    logic [W-1:0] reduced;

    // Shift, compare, and conditionally subtract.
    always_comb begin
        widened = {rem_i, work_i[W-1]};
        fits    = (widened >= {1'b0, den_i});
        reduced = widened[W-1:0] - den_i;
        rem_o   = fits ? reduced : widened[W-1:0];
        work_o  = {work_i[W-2:0], fits};
    end

endmodule

// File: rtl/div_sign_fix.sv
// div_sign_fix: applies the two's-complement negation to the finished
// magnitude quotient when the sign flag is set.
module div_sign_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] mag_i,
    input  logic         negate_i,
    output logic [W-1:0] result_o
);

    // Conditional negation of the loop result.
    always_comb begin
        result_o = negate_i ? (~mag_i + 1'b1) : mag_i;
    end

endmodule

// File: rtl/iter_divider.sv
// iter_divider: sequential integer divider with a start/done handshake.
// Loads operands in the start cycle, runs W restoring iterations, then spends
// one cycle on the sign fix while raising done for one cycle.
// Assumes start is ignored unless idle; synchronous active-low reset.
module iter_divider
    import iter_divider_pkg::*;
#(
    parameter int W    = 32,
    parameter int OP_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    dividend_i,
    input  logic [W-1:0]    divisor_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [W-1:0]    quotient_o
);

    localparam int             CNT_W    = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(W - 1);

    div_state_e     state_q;
    logic [W-1:0]   rem_q;
    logic [W-1:0]   work_q;
    logic [W-1:0]   den_q;
    logic           neg_q;
    logic [CNT_W-1:0] iter_q;
    logic [W-1:0]   quot_q;
    logic           done_q;

    logic           is_signed;
    logic [W-1:0]   num_mag;
    logic [W-1:0]   den_mag;
    logic           negate;
    logic [W-1:0]   rem_nx;
    logic [W-1:0]   work_nx;
    logic [W-1:0]   fixed;
    logic           accept;

    // Operation decode and start acceptance.
    always_comb begin
        is_signed = (op_i == OP_W'(OPC_SIGNED));
        accept    = start_i && (state_q == ST_IDLE);
    end

    div_sign_prep #(.W(W)) prep_i (
        .is_signed_i (is_signed),
        .num_i       (dividend_i),
        .den_i       (divisor_i),
        .num_mag_o   (num_mag),
        .den_mag_o   (den_mag),
        .negate_o    (negate)
    );

    div_step #(.W(W)) step_i (
        .rem_i  (rem_q),
        .work_i (work_q),
        .den_i  (den_q),
        .rem_o  (rem_nx),
        .work_o (work_nx)
    );

    div_sign_fix #(.W(W)) fix_i (
        .mag_i    (work_q),
        .negate_i (neg_q),
        .result_o (fixed)
    );

    // Controller: idle -> run (W iterations) -> fix -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_RUN;
                    iter_q  <= '0;
                end
                ST_RUN: begin
                    iter_q <= iter_q + 1'b1;
                    if (iter_q == LAST_IT) state_q <= ST_FIX;
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Datapath: load magnitudes on start, iterate while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            work_q <= '0;
            den_q  <= '0;
            neg_q  <= 1'b0;
        end else if (accept) begin
            rem_q  <= '0;
            work_q <= num_mag;
            den_q  <= den_mag;
            neg_q  <= negate;
        end else if (state_q == ST_RUN) begin
            rem_q  <= rem_nx;
            work_q <= work_nx;
        end
    end

    // Result register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FIX);
            if (state_q == ST_FIX) quot_q <= fixed;
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign quotient_o = quot_q;

endmodule

// File: rtl/iter_divider_chk.sv
// iter_divider_chk: protocol checker for iter_divider, attached by bind.
// Counts busy cycles since the accepted start to check latency without deep $past.
module iter_divider_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] quotient_o
);

    localparam int RC_W = $clog2(W + 2) + 1;
    logic [RC_W-1:0] run_cnt;

    // Busy-cycle counter restarted by each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_cnt <= '0;
        else if (start_i && !busy_o) run_cnt <= '0;
        else if (busy_o)            run_cnt <= run_cnt + 1'b1;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && quotient_o == '0));

    a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r2_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_cnt == RC_W'(W + 1)));

    a_r9_quotient_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(quotient_o) |-> done_o);

endmodule

bind iter_divider iter_divider_chk #(.W(W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .quotient_o (quotient_o)
);

// File: tb/iter_divider_tb_top.sv
// Bench for iter_divider: directed corners plus seeded random divisions,
// checked against a bench model of truncating signed/unsigned division.
module iter_divider_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  op_i = 6'h24;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [31:0] quotient_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    iter_divider dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o), .quotient_o(quotient_o)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [5:0] op);
        logic sg, ng;
        logic [31:0] ma, mb, q;
        sg = (op == 6'h25);
        ng = sg && (a[31] ^ b[31]);
        ma = (sg && a[31]) ? -a : a;
        mb = (sg && b[31]) ? -b : b;
        q  = (mb == 0) ? 32'hFFFF_FFFF : ma / mb;
        return ng ? -q : q;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue a division at a falling edge; return at the falling edge where done is seen.
    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [5:0] op,
                       input string req, input bit inject);
        int n;
        logic [31:0] exp;
        exp = model(a, b, op);
        dividend_i = a; divisor_i = b; op_i = op; start_i = 1'b1;
        n = 0;
        for (int k = 0; k < 100; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (inject && n == 5) begin
                start_i = 1'b1;               // R2: must be ignored while busy
                dividend_i = $urandom; divisor_i = 32'd3; op_i = 6'h24;
            end else begin
                start_i = 1'b0;
            end
            if (done_o) break;
        end
        check("R3 latency", 32'(n), 32'd34);
        check(req, quotient_o, exp);
    endtask

    initial begin
        process::self().srandom(32'd2024);
        repeat (3) @(negedge clk);
        check("R1 busy", {31'd0, busy_o}, 32'd0);
        check("R1 done", {31'd0, done_o}, 32'd0);
        check("R1 quotient", quotient_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run(32'd43, 32'd7, 6'h24, "R4 unsigned 43/7", 0);
        run(32'hFFFF_FFFF, 32'd1, 6'h24, "R4 unsigned max/1", 0);
        run(32'hFFFF_FFF9, 32'd7, 6'h24, "R4 unsigned big", 0);
        run(32'hFFFF_FFD5, 32'd7, 6'h25, "R5 signed -43/7", 0);
        run(32'd43, 32'hFFFF_FFF9, 6'h25, "R5 signed 43/-7", 0);
        run(32'hFFFF_FFD5, 32'hFFFF_FFF9, 6'h25, "R5 signed -43/-7", 0);
        run(32'hFFFF_FFD5, 32'd7, 6'h00, "R6 code 0x00 unsigned", 0);
        run(32'hFFFF_FFD5, 32'd7, 6'h3F, "R6 code 0x3F unsigned", 0);
        run(32'd1234, 32'd0, 6'h24, "R7 unsigned by zero", 0);
        run(32'd1234, 32'd0, 6'h25, "R7 signed positive by zero", 0);
        run(32'hFFFF_0000, 32'd0, 6'h25, "R7 signed negative by zero", 0);
        check("R7 literal value", quotient_o, 32'd1);
        run(32'h8000_0000, 32'hFFFF_FFFF, 6'h25, "R8 min/-1", 0);
        run(32'h8000_0000, 32'd1, 6'h25, "R8 min/1", 0);
        run(32'h8000_0000, 32'd2, 6'h25, "R8 min/2", 0);
        check("R8 literal value", quotient_o, 32'hC000_0000);
        run(32'd1000, 32'd10, 6'h24, "R2 start while busy ignored", 1);

        // R9: quotient holds, done drops after one cycle.
        begin
            logic [31:0] held;
            held = quotient_o;
            @(negedge clk);
            check("R3 done drops", {31'd0, done_o}, 32'd0);
            dividend_i = 32'd77; divisor_i = 32'd5;
            repeat (10) @(negedge clk);
            check("R9 quotient holds", quotient_o, held);
            check("R2 idle without start", {31'd0, busy_o}, 32'd0);
        end

        // R10: back-to-back runs start in the done cycle; some with idle gaps.
        for (int i = 0; i < 200; i++) begin
            logic [31:0] a, b;
            logic [5:0] op;
            a = $urandom;
            b = $urandom;
            case ($urandom % 4)
                0: b = b >> ($urandom % 32);
                1: b = 32'($urandom % 16);
                default: ;
            endcase
            op = ($urandom % 2 == 0) ? 6'h25 : 6'h24;
            if (i % 17 == 0) repeat (3) @(negedge clk);
            run(a, b, op, (op == 6'h25) ? "R10 R5 random signed" : "R10 R4 random unsigned",
                (i % 23 == 0));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule